// File: doc/BRIEF.md
# Embedded Flash Operation Sequencer

This block turns one-cycle requests for a word program, a page erase or a word read into the strobe sequences that a pair of embedded NOR-flash macros expect. A register front end supplies the request, a latched address, page number, area choice and write word, and ten runtime cycle counts. One for each phase length. The sequencer walks a phase state machine with one shared down-counter, steers the strobes, chip selects and area selects to the chosen macro, and reports busy while a sequence runs.

Program completion and erase completion each give a one-cycle done pulse in the first idle cycle. A read ends with a one-cycle valid flag that carries the word taken from the selected macro. Requests that arrive while the block is busy are dropped.

Top module: `nvm_op_sequencer`

## Requirements
- R1: After reset, busy, every strobe, chip select and area select, both done pulses and the read valid flag are low.
- R2: A request seen in an idle cycle is accepted, and busy is high from the next cycle. When several requests arrive together, program wins over erase and erase wins over read.
- R3: Requests seen while busy is high have no effect. No further operation follows, and busy stays low after the current one ends.
- R4: A program runs these phases, with the strobe levels {program, erase, nvstr, read cs} given for each: program setup 1000, address setup 1000, NVSTR setup 1010, program pulse 1010, address hold 1010, program hold 1010, NVSTR hold 0010, recovery 0000. Each phase lasts its timing input in cycles.
- R5: An erase runs these phases: NVSTR setup 0100, erase pulse 0110, NVSTR hold 0010, recovery 0000. Each phase lasts its timing input in cycles.
- R6: A read holds its chip select for the read-access count. In the next cycle busy is low and read valid is high for one cycle, with the 32-bit word of the selected macro. A read gives no done pulse.
- R7: A timing input of zero gives a phase of exactly one cycle.
- R8: A program gives a one-cycle program-done pulse and an erase gives a one-cycle erase-done pulse. The pulse comes in the first cycle after busy falls.
- R9: For program and read, the target macro is address bit 15. For erase, the target macro is page bit 8. While busy, only the target macro's strobes and selects can be high. Its main-area select is high when the information flag was 0, and its information-area select is high when the flag was 1.
- R10: For program and read, the row output is address bits 14:5 and the column output is address bits 4:0. For erase, the row output is {page bits 7:0, 2'b00} and the column output is 0. Address, page, area, macro and write word are all latched when the request is accepted.
- R11: The phase counter only counts down, except when it is reloaded at a phase change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_prog | input | 1 | One-cycle program request |
| req_erase | input | 1 | One-cycle page-erase request |
| req_read | input | 1 | One-cycle read request |
| req_addr | input | 16 | Word address; bit 15 is the macro, bits 14:0 are row and column |
| req_page | input | 9 | Erase page; bit 8 is the macro |
| req_info | input | 1 | 1 selects the information area, 0 the main area |
| req_wdata | input | 32 | Word to program |
| t_nvs_setup | input | 12 | NVSTR setup cycles |
| t_nvs_hold | input | 12 | NVSTR hold cycles |
| t_recover | input | 8 | Recovery cycles |
| t_prg_setup | input | 16 | Program setup cycles |
| t_prg_hold | input | 4 | Program hold cycles |
| t_adr_setup | input | 4 | Address setup cycles |
| t_adr_hold | input | 4 | Address hold cycles |
| t_prg_pulse | input | 16 | Program pulse cycles |
| t_rd_access | input | 8 | Read access cycles |
| t_erase | input | 24 | Page-erase pulse cycles |
| mac_rdata | input | 64 | Read words of both macros, macro 0 in the low half |
| mac_prog | output | 2 | Program strobe per macro |
| mac_erase | output | 2 | Erase strobe per macro |
| mac_nvstr | output | 2 | NVSTR strobe per macro |
| mac_rd_cs | output | 2 | Read chip select per macro |
| mac_main_sel | output | 2 | Main-area select per macro |
| mac_info_sel | output | 2 | Information-area select per macro |
| mac_xaddr | output | 10 | Row address |
| mac_yaddr | output | 5 | Column address |
| mac_wdata | output | 32 | Word to program |
| busy | output | 1 | Sequence in progress |
| prog_done | output | 1 | One-cycle program completion |
| erase_done | output | 1 | One-cycle erase completion |
| rd_valid | output | 1 | One-cycle read data valid |
| rd_data | output | 32 | Read word |

## Verification
Each of the three operations is run with random small timing counts, so unequal phase lengths show whether the phase order or a boundary is wrong. A run with all counts at zero separates a skipped phase from a one-cycle phase. A program run with the realistic default counts exercises wide counter values. Random macro, area and address bits tell the per-macro steering and the row/column mapping apart, and the request inputs are scrambled after acceptance to show that the values were latched. Simultaneous requests check the priority order, and request pulses placed at random points inside a sequence show that the block ignores them while busy.

// File: rtl/nvm_seq_pkg.sv
package nvm_seq_pkg;

    // Timing input widths
    localparam int TW_NVS    = 12;
    localparam int TW_RCV    = 8;
    localparam int TW_PSETUP = 16;
    localparam int TW_SHORT  = 4;
    localparam int TW_PPULSE = 16;
    localparam int TW_RACC   = 8;
    localparam int TW_ERASE  = 24;

    // Suggested register defaults for the front end
    localparam int DEF_NVS    = 'h259;
    localparam int DEF_RCV    = 'h79;
    localparam int DEF_PSETUP = 'h4B1;
    localparam int DEF_SHORT  = 3;
    localparam int DEF_PPULSE = 'h962;
    localparam int DEF_RACC   = 5;
    localparam int DEF_ERASE  = 'h24A2C1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_P_SETUP,
        ST_P_ADDR,
        ST_P_NVS,
        ST_P_PULSE,
        ST_P_AHOLD,
        ST_P_PHOLD,
        ST_E_SETUP,
        ST_E_PULSE,
        ST_NV_HOLD,
        ST_RECOVER,
        ST_R_ACCESS
    } phase_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_PROG,
        OP_ERASE,
        OP_READ
    } op_e;

endpackage

// File: rtl/nvm_phase_timer.sv
module nvm_phase_timer #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            // a zero count still gives a one-cycle phase
            cnt_d = (load_val == '0) ? '0 : load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == '0);

    // R11: without a reload the counter only steps down by one or rests at zero
    a_r11_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) && ($past(cnt_q) != '0) |-> cnt_q == $past(cnt_q) - CNT_W'(1));

endmodule

// File: rtl/nvm_macro_steer.sv
module nvm_macro_steer #(
    parameter int N_MACRO = 2,
    parameter int MSEL_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MSEL_W-1:0] mac_sel,
    input  logic              info,
    input  logic              active,
    input  logic              prog_on,
    input  logic              erase_on,
    input  logic              nvstr_on,
    input  logic              rd_on,
    output logic [N_MACRO-1:0] prog_o,
    output logic [N_MACRO-1:0] erase_o,
    output logic [N_MACRO-1:0] nvstr_o,
    output logic [N_MACRO-1:0] rd_cs_o,
    output logic [N_MACRO-1:0] main_o,
    output logic [N_MACRO-1:0] info_o
);
    for (genvar i = 0; i < N_MACRO; i++) begin : g_macro
        logic hit;
        assign hit        = active && (mac_sel == MSEL_W'(i));
        assign prog_o[i]  = hit && prog_on;
        assign erase_o[i] = hit && erase_on;
        assign nvstr_o[i] = hit && nvstr_on;
        assign rd_cs_o[i] = hit && rd_on;
        assign main_o[i]  = hit && !info;
        assign info_o[i]  = hit && info;
    end

    // R9: at most one macro is addressed at a time
    a_r9_one_macro: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(main_o | info_o) && $onehot0(rd_cs_o | prog_o | erase_o));

endmodule

// File: rtl/nvm_op_sequencer.sv
module nvm_op_sequencer
    import nvm_seq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ROW_W   = 10,
    parameter int COL_W   = 5,
    parameter int N_MACRO = 2,
    parameter int PAGE_W  = 9,
    parameter int CNT_W   = 24,
    localparam int MSEL_W  = $clog2(N_MACRO),
    localparam int WADDR_W = ROW_W + COL_W,
    localparam int PROW_W  = PAGE_W - MSEL_W,
    localparam int ROW_PAD = ROW_W - PROW_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_prog,
    input  logic                        req_erase,
    input  logic                        req_read,
    input  logic [WADDR_W+MSEL_W-1:0]   req_addr,
    input  logic [PAGE_W-1:0]           req_page,
    input  logic                        req_info,
    input  logic [DATA_W-1:0]           req_wdata,
    input  logic [TW_NVS-1:0]           t_nvs_setup,
    input  logic [TW_NVS-1:0]           t_nvs_hold,
    input  logic [TW_RCV-1:0]           t_recover,
    input  logic [TW_PSETUP-1:0]        t_prg_setup,
    input  logic [TW_SHORT-1:0]         t_prg_hold,
    input  logic [TW_SHORT-1:0]         t_adr_setup,
    input  logic [TW_SHORT-1:0]         t_adr_hold,
    input  logic [TW_PPULSE-1:0]        t_prg_pulse,
    input  logic [TW_RACC-1:0]          t_rd_access,
    input  logic [TW_ERASE-1:0]         t_erase,
    input  logic [N_MACRO*DATA_W-1:0]   mac_rdata,
    output logic [N_MACRO-1:0]          mac_prog,
    output logic [N_MACRO-1:0]          mac_erase,
    output logic [N_MACRO-1:0]          mac_nvstr,
    output logic [N_MACRO-1:0]          mac_rd_cs,
    output logic [N_MACRO-1:0]          mac_main_sel,
    output logic [N_MACRO-1:0]          mac_info_sel,
    output logic [ROW_W-1:0]            mac_xaddr,
    output logic [COL_W-1:0]            mac_yaddr,
    output logic [DATA_W-1:0]           mac_wdata,
    output logic                        busy,
    output logic                        prog_done,
    output logic                        erase_done,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data
);

    typedef struct packed {
        phase_e              ph;
        op_e                 op;
        logic [MSEL_W-1:0]   mac;
        logic                info;
        logic [WADDR_W-1:0]  waddr;
        logic [PAGE_W-1:0]   page;
        logic [DATA_W-1:0]   wdata;
        logic                p_done;
        logic                e_done;
        logic                r_valid;
        logic [DATA_W-1:0]   r_data;
    } seq_t;

    seq_t s_d, s_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expire;
    logic [DATA_W-1:0] sel_rdata;

    assign sel_rdata = mac_rdata[int'(s_q.mac)*DATA_W +: DATA_W];

    // Next-state computation
    always_comb begin
        s_d         = s_q;
        s_d.p_done  = 1'b0;
        s_d.e_done  = 1'b0;
        s_d.r_valid = 1'b0;
        unique case (s_q.ph)
            ST_IDLE: begin
                if (req_prog || req_read) begin
                    s_d.waddr = req_addr[WADDR_W-1:0];
                    s_d.mac   = req_addr[WADDR_W +: MSEL_W];
                    s_d.info  = req_info;
                    s_d.wdata = req_wdata;
                end
                if (req_prog) begin
                    s_d.ph = ST_P_SETUP;
                    s_d.op = OP_PROG;
                end else if (req_erase) begin
                    s_d.ph   = ST_E_SETUP;
                    s_d.op   = OP_ERASE;
                    s_d.page = req_page;
                    s_d.mac  = req_page[PAGE_W-1 -: MSEL_W];
                    s_d.info = req_info;
                end else if (req_read) begin
                    s_d.ph = ST_R_ACCESS;
                    s_d.op = OP_READ;
                end
            end
            ST_P_SETUP:  if (tmr_expire) s_d.ph = ST_P_ADDR;
            ST_P_ADDR:   if (tmr_expire) s_d.ph = ST_P_NVS;
            ST_P_NVS:    if (tmr_expire) s_d.ph = ST_P_PULSE;
            ST_P_PULSE:  if (tmr_expire) s_d.ph = ST_P_AHOLD;
            ST_P_AHOLD:  if (tmr_expire) s_d.ph = ST_P_PHOLD;
            ST_P_PHOLD:  if (tmr_expire) s_d.ph = ST_NV_HOLD;
            ST_E_SETUP:  if (tmr_expire) s_d.ph = ST_E_PULSE;
            ST_E_PULSE:  if (tmr_expire) s_d.ph = ST_NV_HOLD;
            ST_NV_HOLD:  if (tmr_expire) s_d.ph = ST_RECOVER;
            ST_RECOVER: begin
                if (tmr_expire) begin
                    s_d.ph     = ST_IDLE;
                    s_d.p_done = (s_q.op == OP_PROG);
                    s_d.e_done = (s_q.op == OP_ERASE);
                end
            end
            ST_R_ACCESS: begin
                if (tmr_expire) begin
                    s_d.ph      = ST_IDLE;
                    s_d.r_valid = 1'b1;
                    s_d.r_data  = sel_rdata;
                end
            end
            default: s_d.ph = ST_IDLE;
        endcase
    end

    // Counter reload on every entry into a timed phase
    always_comb begin
        tmr_load = (s_d.ph != s_q.ph) && (s_d.ph != ST_IDLE);
        unique case (s_d.ph)
            ST_P_SETUP:  tmr_val = CNT_W'(t_prg_setup);
            ST_P_ADDR:   tmr_val = CNT_W'(t_adr_setup);
            ST_P_NVS:    tmr_val = CNT_W'(t_nvs_setup);
            ST_P_PULSE:  tmr_val = CNT_W'(t_prg_pulse);
            ST_P_AHOLD:  tmr_val = CNT_W'(t_adr_hold);
            ST_P_PHOLD:  tmr_val = CNT_W'(t_prg_hold);
            ST_E_SETUP:  tmr_val = CNT_W'(t_nvs_setup);
            ST_E_PULSE:  tmr_val = CNT_W'(t_erase);
            ST_NV_HOLD:  tmr_val = CNT_W'(t_nvs_hold);
            ST_RECOVER:  tmr_val = CNT_W'(t_recover);
            ST_R_ACCESS: tmr_val = CNT_W'(t_rd_access);
            default:     tmr_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.ph <= ST_IDLE;
            s_q.op <= OP_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    nvm_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expire   (tmr_expire)
    );

    // Strobe levels per phase
    logic prog_on, erase_on, nvstr_on, rd_on;
    always_comb begin
        prog_on  = s_q.ph inside {ST_P_SETUP, ST_P_ADDR, ST_P_NVS, ST_P_PULSE,
                                  ST_P_AHOLD, ST_P_PHOLD};
        erase_on = s_q.ph inside {ST_E_SETUP, ST_E_PULSE};
        nvstr_on = s_q.ph inside {ST_P_NVS, ST_P_PULSE, ST_P_AHOLD, ST_P_PHOLD,
                                  ST_E_PULSE, ST_NV_HOLD};
        rd_on    = (s_q.ph == ST_R_ACCESS);
    end

    assign busy = (s_q.ph != ST_IDLE);

    nvm_macro_steer #(.N_MACRO(N_MACRO), .MSEL_W(MSEL_W)) i_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .mac_sel  (s_q.mac),
        .info     (s_q.info),
        .active   (busy),
        .prog_on  (prog_on),
        .erase_on (erase_on),
        .nvstr_on (nvstr_on),
        .rd_on    (rd_on),
        .prog_o   (mac_prog),
        .erase_o  (mac_erase),
        .nvstr_o  (mac_nvstr),
        .rd_cs_o  (mac_rd_cs),
        .main_o   (mac_main_sel),
        .info_o   (mac_info_sel)
    );

    assign mac_xaddr  = (s_q.op == OP_ERASE) ? {s_q.page[PROW_W-1:0], {ROW_PAD{1'b0}}}
                                             : s_q.waddr[WADDR_W-1:COL_W];
    assign mac_yaddr  = (s_q.op == OP_ERASE) ? '0 : s_q.waddr[COL_W-1:0];
    assign mac_wdata  = s_q.wdata;
    assign prog_done  = s_q.p_done;
    assign erase_done = s_q.e_done;
    assign rd_valid   = s_q.r_valid;
    assign rd_data    = s_q.r_data;

    // R2: a program request in an idle cycle always starts a program
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && req_prog |=> busy && prog_on);

    // R3: the operation kind never changes during a sequence
    a_r3_op_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(s_q.op));

    // R4: program and erase strobes never overlap
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !((|mac_prog) && (|mac_erase)));

    // R8: a done pulse only follows a busy cycle and lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_done || erase_done) |-> !busy && $past(busy) && !$past(prog_done || erase_done));

    // R6: read data valid only right after the access phase
    a_r6_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !busy && $past(rd_on) && !prog_done && !erase_done);

endmodule

// File: tb/test_nvm_op_sequencer.sv
module test_nvm_op_sequencer;
    import nvm_seq_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_prog = 0, req_erase = 0, req_read = 0;
    logic [15:0] req_addr = '0;
    logic [8:0]  req_page = '0;
    logic        req_info = 0;
    logic [31:0] req_wdata = '0;
    logic [11:0] t_nvs_setup, t_nvs_hold;
    logic [7:0]  t_recover, t_rd_access;
    logic [15:0] t_prg_setup, t_prg_pulse;
    logic [3:0]  t_prg_hold, t_adr_setup, t_adr_hold;
    logic [23:0] t_erase;
    logic [63:0] mac_rdata = '0;
    logic [1:0]  mac_prog, mac_erase, mac_nvstr, mac_rd_cs, mac_main_sel, mac_info_sel;
    logic [9:0]  mac_xaddr;
    logic [4:0]  mac_yaddr;
    logic [31:0] mac_wdata, rd_data;
    logic        busy, prog_done, erase_done, rd_valid;

    nvm_op_sequencer i_nvm_op_sequencer (.*);

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int lens[8];
    logic [3:0] pats[8];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int eff(input int t);
        return (t == 0) ? 1 : t;
    endfunction

    task automatic set_timing(input int maxv);
        t_nvs_setup = 12'($urandom_range(0, maxv));
        t_nvs_hold  = 12'($urandom_range(0, maxv));
        t_recover   = 8'($urandom_range(0, maxv));
        t_prg_setup = 16'($urandom_range(0, maxv));
        t_prg_hold  = 4'($urandom_range(0, maxv));
        t_adr_setup = 4'($urandom_range(0, maxv));
        t_adr_hold  = 4'($urandom_range(0, maxv));
        t_prg_pulse = 16'($urandom_range(0, maxv));
        t_rd_access = 8'($urandom_range(0, maxv));
        t_erase     = 24'($urandom_range(0, maxv));
    endtask

    // kind: 0 program, 1 erase, 2 read
    task automatic run_op(input int kind, input bit all_req, input int inject_at);
        logic [15:0] a  = 16'($urandom);
        logic [8:0]  pg = 9'($urandom);
        bit          inf = 1'($urandom);
        logic [31:0] wd = $urandom;
        int nph = 0, total = 0, m, bad_s = 0, bad_a = 0;
        logic [63:0] s_act = 0, s_exp = 0, a_act = 0, a_exp = 0;
        logic [1:0] oh;
        string tg;
        mac_rdata = {$urandom, $urandom};
        if (kind == 0) begin
            nph = 8; m = a[15];
            lens[0] = eff(t_prg_setup); pats[0] = 4'b1000;
            lens[1] = eff(t_adr_setup); pats[1] = 4'b1000;
            lens[2] = eff(t_nvs_setup); pats[2] = 4'b1010;
            lens[3] = eff(t_prg_pulse); pats[3] = 4'b1010;
            lens[4] = eff(t_adr_hold);  pats[4] = 4'b1010;
            lens[5] = eff(t_prg_hold);  pats[5] = 4'b1010;
            lens[6] = eff(t_nvs_hold);  pats[6] = 4'b0010;
            lens[7] = eff(t_recover);   pats[7] = 4'b0000;
            tg = "R4";
        end else if (kind == 1) begin
            nph = 4; m = pg[8];
            lens[0] = eff(t_nvs_setup); pats[0] = 4'b0100;
            lens[1] = eff(int'(t_erase)); pats[1] = 4'b0110;
            lens[2] = eff(t_nvs_hold);  pats[2] = 4'b0010;
            lens[3] = eff(t_recover);   pats[3] = 4'b0000;
            tg = "R5";
        end else begin
            nph = 1; m = a[15];
            lens[0] = eff(t_rd_access); pats[0] = 4'b0001;
            tg = "R6";
        end
        for (int k = 0; k < nph; k++) total += lens[k];
        oh = 2'b01 << m;

        @(negedge clk);
        req_addr = a; req_page = pg; req_info = inf; req_wdata = wd;
        req_prog  = (kind == 0) || all_req;
        req_erase = (kind == 1) || all_req;
        req_read  = (kind == 2) || all_req;
        @(negedge clk);
        req_prog = 0; req_erase = 0; req_read = 0;
        // R10: inputs scrambled after acceptance must not matter
        req_addr = ~a; req_page = ~pg; req_info = ~inf; req_wdata = ~wd;

        for (int i = 0; i < total; i++) begin
            int acc = 0, ph = 0;
            logic [3:0] p;
            logic [10:0] ev, av;
            logic [29:0] ea, aa;
            while (i >= acc + lens[ph]) begin acc += lens[ph]; ph++; end
            p  = pats[ph];
            ev = {1'b1, p[3] ? oh : 2'b00, p[2] ? oh : 2'b00, p[1] ? oh : 2'b00,
                  p[0] ? oh : 2'b00};
            av = {busy, mac_prog, mac_erase, mac_nvstr, mac_rd_cs};
            if (av != ev && bad_s == 0) begin s_act = 64'(av); s_exp = 64'(ev); end
            if (av != ev) bad_s++;
            ea[29:26] = {inf ? 2'b00 : oh, inf ? oh : 2'b00};
            aa[29:26] = {mac_main_sel, mac_info_sel};
            if (kind == 1) begin
                ea[25:0] = {pg[7:0], 2'b00, 5'd0, 11'd0};
                aa[25:0] = {mac_xaddr, mac_yaddr, 11'd0};
            end else begin
                ea[25:0] = {a[14:5], a[4:0], kind == 0 ? wd[10:0] : 11'd0};
                aa[25:0] = {mac_xaddr, mac_yaddr, kind == 0 ? mac_wdata[10:0] : 11'd0};
            end
            if (aa != ea && bad_a == 0) begin a_act = 64'(aa); a_exp = 64'(ea); end
            if (aa != ea) bad_a++;
            // R3: stray requests during the sequence
            if (i == inject_at) begin req_prog = 1; req_erase = 1; req_read = 1; end
            else begin req_prog = 0; req_erase = 0; req_read = 0; end
            @(negedge clk);
        end
        req_prog = 0; req_erase = 0; req_read = 0;
        chk(bad_s == 0, {tg, "/R7 phase strobes and lengths"}, s_act, s_exp);
        chk(bad_a == 0, "R9/R10 steering and address", a_act, a_exp);
        chk({busy, prog_done, erase_done, rd_valid} ==
            {1'b0, kind == 0, kind == 1, kind == 2}, "R8/R6 end of sequence",
            64'({busy, prog_done, erase_done, rd_valid}),
            64'({1'b0, kind == 0, kind == 1, kind == 2}));
        if (kind == 2)
            chk(rd_data == mac_rdata[m*32 +: 32], "R6 read data",
                64'(rd_data), 64'(mac_rdata[m*32 +: 32]));
        @(negedge clk);
        chk({busy, prog_done, erase_done, rd_valid} == 4'b0000, "R3/R8 pulse one cycle, nothing restarted",
            64'({busy, prog_done, erase_done, rd_valid}), 64'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        set_timing(3);
        repeat (3) @(negedge clk);
        chk({busy, mac_prog, mac_erase, mac_nvstr, mac_rd_cs, mac_main_sel, mac_info_sel,
             prog_done, erase_done, rd_valid} == '0, "R1 state in reset", 64'(busy), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, mac_prog, mac_erase, mac_nvstr, mac_rd_cs, mac_main_sel, mac_info_sel,
             prog_done, erase_done, rd_valid} == '0, "R1 state after reset", 64'(busy), 64'(0));

        // R4 program with realistic counts
        t_nvs_setup = 12'(DEF_NVS);  t_nvs_hold = 12'(DEF_NVS); t_recover = 8'(DEF_RCV);
        t_prg_setup = 16'(DEF_PSETUP); t_prg_hold = 4'(DEF_SHORT); t_adr_setup = 4'(DEF_SHORT);
        t_adr_hold = 4'(DEF_SHORT); t_prg_pulse = 16'(DEF_PPULSE); t_rd_access = 8'(DEF_RACC);
        t_erase = 24'd40;
        run_op(0, 0, -1);
        run_op(1, 0, -1);
        run_op(2, 0, -1);

        // R7 all counts zero
        t_nvs_setup = 0; t_nvs_hold = 0; t_recover = 0; t_prg_setup = 0; t_prg_hold = 0;
        t_adr_setup = 0; t_adr_hold = 0; t_prg_pulse = 0; t_rd_access = 0; t_erase = 0;
        run_op(0, 0, -1);
        run_op(1, 0, 0);
        run_op(2, 0, 0);

        // R2 priority: all requests together
        set_timing(4);
        run_op(0, 1, -1);
        run_op(1, 0, 2);

        // random mix with stray requests
        for (int n = 0; n < 40; n++) begin
            int k = $urandom_range(0, 2);
            set_timing(6);
            run_op(k, 0, ($urandom_range(0, 1) == 1) ? $urandom_range(0, 5) : -1);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule